// File: doc/BRIEF.md
# Clock-Calendar Register Access Master

This block reads and writes single byte-wide registers of a clock-calendar peripheral over a two-wire serial bus. The peripheral answers at a fixed 7-bit bus address, 0x68. A host hands over one request at a time through a valid/ready handshake. The request carries a read/write select, a 6-bit register number and, for a write, one data byte. The block then runs the whole bus conversation and reports the outcome with a one-clock `done` pulse.

Bus sequencing is bit-level. Every individual change of SCL or SDA, and every sampling of SDA, is one micro-step. Each micro-step is followed by a settle interval of `settle_div + 1` clocks, and the host programs `settle_div` to meet the bus timing. A write carries three bytes: the address byte 0xD0, the register number and the data. Each byte is followed by an acknowledge slot. A read first writes the register pointer. It then issues a repeated start, sends 0xD1 and drives the acknowledge low itself. It clocks in eight data bits and closes directly with a stop. Acknowledge values the master samples are collected into a status bit and never abort the sequence.

Back-pressure: a request transfers only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the cycle after `done`. A valid request raised while `req_ready` is low is not stored, and it transfers only if the host still holds it once `req_ready` returns high.

Top module: `clkcal_i2c_master`

## Requirements
- R1: Out of reset, and whenever no transfer is running, `scl_o`=1, `sda_o`=1 and `sda_oe`=1 (bus idle, both lines driven high). In the same state `req_ready`=1, `busy`=0 and `done`=0.
- R2: A write produces a start, the byte 0xD0, an acknowledge slot, the register number, an acknowledge slot, the data byte, an acknowledge slot and a stop. Bytes go out MSB first. While SCL is high, SDA changes only for a start, a repeated start or a stop.
- R3: A read produces a start and 0xD0, each followed by an acknowledge slot. It then sends the register number with its acknowledge slot. Next comes a repeated start (SDA high, SCL high, SDA low) and 0xD1. Eight data bits are then sampled MSB first while SCL is high, and a stop follows. The assembled byte appears on `rsp_rdata`.
- R4: In the clock that follows 0xD1, the master itself drives SDA low (`sda_oe`=1, `sda_o`=0).
- R5: In each acknowledge slot after a byte the master sends, SDA is released (`sda_oe`=0) while it is sampled. `nack_seen` reports 1 at `done` if any such sample of the transfer was high, and 0 otherwise. The transfer runs to its stop in either case.
- R6: Successive bus micro-steps are exactly `settle_div`+1 clocks apart, so any two line changes within a transfer are a whole multiple of that interval apart.
- R7: A write gives exactly 28 rising SCL edges and a read exactly 37.
- R8: A request transfers only when `req_valid` and `req_ready` are both high. `busy` is high from the next cycle until the transfer ends. A request raised while `busy` is high starts no transfer.
- R9: `done` is high for exactly one clock after the stop's settle interval. `rsp_rdata` keeps its value until the next read completes.
- R10: A request for register 0x3F is rejected. `addr_err` pulses for one clock, there is no bus activity, no `done` and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_div | input | 16 | Settle interval minus one, in clocks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_reg | input | 6 | Register number |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Last byte read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| nack_seen | output | 1 | A sampled acknowledge was high |
| addr_err | output | 1 | One-clock pulse on a rejected request |
| scl_o | output | 1 | Serial clock line |
| sda_o | output | 1 | SDA value driven while enabled |
| sda_oe | output | 1 | SDA output enable |
| sda_i | input | 1 | SDA line as seen on the pad |

## Verification
A bench target model with a 64-byte register file takes writes to every legal register, using a data pattern computed from the register number. Every register is then read back, which separates bit-order, pointer and address-byte errors. The bench counts SCL edges, captures the address bytes and checks the master-driven acknowledge. Two settle values separate correct pacing from a fixed or off-by-one interval. A target that never acknowledges shows that `nack_seen` is set without the sequence stopping, and that a read then returns 0xFF. A request for register 0x3F and a request raised during a busy transfer show that neither touches the bus.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_NOP, OP_SCL_LO, OP_SCL_HI, OP_SDA_LO, OP_SDA_HI,
    OP_SDA_BIT, OP_SDA_REL, OP_SDA_DRV, OP_SAMPLE
  } bus_op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_TX, PH_ACKIN, PH_RSTART,
    PH_ACKOUT, PH_RX, PH_STOP, PH_DONE
  } phase_e;

  localparam logic [2:0] MU_PRE = 3'd7;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  output logic             ready
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= div;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/line_driver.sv
module line_driver
  import clkcal_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  bus_op_e op,
  input  logic    bit_val,
  output logic    scl_o,
  output logic    sda_o,
  output logic    sda_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_o  <= 1'b1;
      sda_o  <= 1'b1;
      sda_oe <= 1'b1;
    end else if (fire) begin
      case (op)
        OP_SCL_LO:  scl_o  <= 1'b0;
        OP_SCL_HI:  scl_o  <= 1'b1;
        OP_SDA_LO:  sda_o  <= 1'b0;
        OP_SDA_HI:  sda_o  <= 1'b1;
        OP_SDA_BIT: sda_o  <= bit_val;
        OP_SDA_REL: sda_oe <= 1'b0;
        OP_SDA_DRV: sda_oe <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import clkcal_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h68,
  parameter int         REG_W     = 6,
  parameter logic [REG_W-1:0] REG_LIMIT = 6'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              tick_ready,
  input  logic              sda_i,
  output logic              fire,
  output bus_op_e           op,
  output logic              op_bit,
  output logic [BYTE_W-1:0] rdata,
  output logic              done,
  output logic              nack_seen,
  output logic              addr_err,
  output phase_e            phase
);
  phase_e             ph_q;
  logic [2:0]         mu_q;
  logic [2:0]         bitn_q;
  logic [1:0]         bidx_q;
  logic               rd_q;
  logic [REG_W-1:0]   reg_q;
  logic [BYTE_W-1:0]  wdata_q;
  logic [BYTE_W-1:0]  rx_q;
  logic [BYTE_W-1:0]  tx_byte;
  logic               legal;

  assign legal     = (req_reg < REG_LIMIT);
  assign req_ready = (ph_q == PH_IDLE);
  assign fire      = (ph_q != PH_IDLE) && tick_ready;
  assign phase     = ph_q;

  always_comb begin
    case (bidx_q)
      2'd0:    tx_byte = {DEV_ADDR, 1'b0};
      2'd1:    tx_byte = BYTE_W'(reg_q);
      default: tx_byte = rd_q ? {DEV_ADDR, 1'b1} : wdata_q;
    endcase
  end
  assign op_bit = tx_byte[bitn_q];

  always_comb begin
    op = OP_NOP;
    case (ph_q)
      PH_START:  op = (mu_q == 3'd0) ? OP_SCL_HI : (mu_q == 3'd1) ? OP_SDA_HI : OP_SDA_LO;
      PH_TX:     op = (mu_q == MU_PRE) ? OP_SCL_LO : (mu_q == 3'd0) ? OP_SDA_BIT :
                      (mu_q == 3'd1) ? OP_SCL_HI : OP_SCL_LO;
      PH_ACKIN: begin
        case (mu_q)
          3'd0:    op = OP_SDA_REL;
          3'd1:    op = OP_SCL_HI;
          3'd2:    op = OP_SAMPLE;
          3'd3:    op = OP_SCL_LO;
          default: op = OP_SDA_DRV;
        endcase
      end
      PH_RSTART: op = (mu_q == 3'd1) ? OP_SCL_HI : (mu_q == 3'd3) ? OP_SDA_LO : OP_SDA_HI;
      PH_ACKOUT: op = (mu_q == 3'd0) ? OP_SDA_LO : (mu_q == 3'd1) ? OP_SCL_HI : OP_SCL_LO;
      PH_RX: begin
        case (mu_q)
          MU_PRE:  op = OP_SCL_LO;
          3'd6:    op = OP_SDA_REL;
          3'd0:    op = OP_SCL_HI;
          3'd1:    op = OP_SAMPLE;
          3'd2:    op = OP_SCL_LO;
          default: op = OP_SDA_DRV;
        endcase
      end
      PH_STOP:   op = (mu_q == 3'd0) ? OP_SDA_LO : (mu_q == 3'd1) ? OP_SCL_HI : OP_SDA_HI;
      default:   op = OP_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      mu_q      <= '0;
      bitn_q    <= '0;
      bidx_q    <= '0;
      rd_q      <= 1'b0;
      reg_q     <= '0;
      wdata_q   <= '0;
      rx_q      <= '0;
      rdata     <= '0;
      done      <= 1'b0;
      nack_seen <= 1'b0;
      addr_err  <= 1'b0;
    end else begin
      done     <= 1'b0;
      addr_err <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (req_valid && legal) begin
          ph_q      <= PH_START;
          mu_q      <= '0;
          bidx_q    <= '0;
          rd_q      <= req_rd;
          reg_q     <= req_reg;
          wdata_q   <= req_wdata;
          nack_seen <= 1'b0;
        end else if (req_valid) begin
          addr_err <= 1'b1;
        end
      end else if (fire) begin
        case (ph_q)
          PH_START: begin
            if (mu_q == 3'd2) begin ph_q <= PH_TX; mu_q <= MU_PRE; end
            else mu_q <= mu_q + 1'b1;
          end
          PH_TX: begin
            if (mu_q == MU_PRE) begin
              mu_q <= '0; bitn_q <= 3'd7;
            end else if (mu_q == 3'd2) begin
              mu_q <= '0;
              if (bitn_q == 3'd0)
                ph_q <= (rd_q && bidx_q == 2'd2) ? PH_ACKOUT : PH_ACKIN;
              else
                bitn_q <= bitn_q - 1'b1;
            end else mu_q <= mu_q + 1'b1;
          end
          PH_ACKIN: begin
            if (mu_q == 3'd2) nack_seen <= nack_seen | sda_i;
            if (mu_q == 3'd4) begin
              mu_q <= MU_PRE;
              case (bidx_q)
                2'd0: begin ph_q <= PH_TX; bidx_q <= 2'd1; end
                2'd1: begin
                  if (rd_q) begin ph_q <= PH_RSTART; mu_q <= '0; end
                  else begin ph_q <= PH_TX; bidx_q <= 2'd2; end
                end
                default: begin ph_q <= PH_STOP; mu_q <= '0; end
              endcase
            end else mu_q <= mu_q + 1'b1;
          end
          PH_RSTART: begin
            if (mu_q == 3'd3) begin ph_q <= PH_TX; mu_q <= MU_PRE; bidx_q <= 2'd2; end
            else mu_q <= mu_q + 1'b1;
          end
          PH_ACKOUT: begin
            if (mu_q == 3'd2) begin ph_q <= PH_RX; mu_q <= MU_PRE; end
            else mu_q <= mu_q + 1'b1;
          end
          PH_RX: begin
            case (mu_q)
              MU_PRE: mu_q <= 3'd6;
              3'd6:   begin mu_q <= '0; bitn_q <= 3'd7; end
              3'd0:   mu_q <= 3'd1;
              3'd1:   begin rx_q <= {rx_q[BYTE_W-2:0], sda_i}; mu_q <= 3'd2; end
              3'd2: begin
                if (bitn_q == 3'd0) mu_q <= 3'd5;
                else begin bitn_q <= bitn_q - 1'b1; mu_q <= '0; end
              end
              default: begin ph_q <= PH_STOP; mu_q <= '0; end
            endcase
          end
          PH_STOP: begin
            if (mu_q == 3'd2) ph_q <= PH_DONE;
            else mu_q <= mu_q + 1'b1;
          end
          default: begin
            ph_q <= PH_IDLE;
            done <= 1'b1;
            if (rd_q) rdata <= rx_q;
          end
        endcase
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (ph_q == PH_IDLE));
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && legal) |=> (ph_q == PH_START));
endmodule

// File: rtl/clkcal_i2c_master.sv
module clkcal_i2c_master
  import clkcal_pkg::*;
#(
  parameter int         DIV_W     = 16,
  parameter int         REG_W     = 6,
  parameter logic [6:0] DEV_ADDR  = 7'h68,
  parameter logic [REG_W-1:0] REG_LIMIT = 6'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  settle_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              nack_seen,
  output logic              addr_err,
  output logic              scl_o,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic              sda_i
);
  logic    tick_ready;
  logic    fire;
  logic    op_bit;
  bus_op_e op;
  phase_e  seq_ph;

  settle_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(fire), .div(settle_div), .ready(tick_ready)
  );

  xfer_sequencer #(.DEV_ADDR(DEV_ADDR), .REG_W(REG_W), .REG_LIMIT(REG_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_ready(req_ready),
    .tick_ready(tick_ready), .sda_i(sda_i), .fire(fire), .op(op),
    .op_bit(op_bit), .rdata(rsp_rdata), .done(done), .nack_seen(nack_seen),
    .addr_err(addr_err), .phase(seq_ph)
  );

  line_driver u_lines (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(op), .bit_val(op_bit),
    .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe)
  );

  assign busy = !req_ready;

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && sda_o && sda_oe));
  assert_sda_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && sda_oe && (sda_o != $past(sda_o)))
      |-> ($past(seq_ph) inside {PH_START, PH_RSTART, PH_STOP}));
  assert_ack_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_SAMPLE) |-> !sda_oe);
  assert_settle_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && settle_div != '0) |=> !fire);
endmodule

// File: tb/clkcal_i2c_master_tb.sv
module clkcal_i2c_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] settle_div;
  logic        req_valid, req_rd;
  logic [5:0]  req_reg;
  logic [7:0]  req_wdata;
  logic        req_ready, busy, done, nack_seen, addr_err;
  logic [7:0]  rsp_rdata;
  logic        scl_o, sda_o, sda_oe, sda_i;
  logic        slave_low = 1'b0;
  logic        nack_mode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_i = slave_low ? 1'b0 : (sda_oe ? sda_o : 1'b1);

  clkcal_i2c_master u_dut (
    .clk(clk), .rst_n(rst_n), .settle_div(settle_div), .req_valid(req_valid),
    .req_ready(req_ready), .req_rd(req_rd), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .busy(busy), .done(done),
    .nack_seen(nack_seen), .addr_err(addr_err), .scl_o(scl_o), .sda_o(sda_o),
    .sda_oe(sda_oe), .sda_i(sda_i)
  );

  // target model and bus statistics, all evaluated at the falling clock edge
  typedef enum {S_IDLE, S_ADDR, S_REG, S_WDAT, S_RD} sst_e;
  sst_e       st;
  logic [7:0] mem [0:63];
  logic [7:0] sh;
  logic [5:0] ptr;
  int         bc;
  logic       p_scl, p_ln, p_sdo, p_oe, p_busy;
  int         scl_rises, n_addr, last_chg, min_gap, gap_bad;
  logic [7:0] addr_log [0:1];
  logic [7:0] reg_seen;
  logic       mack_ok, mack_hit;

  always @(negedge clk) begin
    logic ln;
    ln = sda_i;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] = 8'hA5 ^ 8'(i);
      st = S_IDLE; bc = 0; sh = 0; ptr = 0; slave_low = 1'b0;
      scl_rises = 0; n_addr = 0; last_chg = -1; min_gap = 1 << 30; gap_bad = 0;
      mack_ok = 0; mack_hit = 0; reg_seen = 0;
    end else begin
      if (busy && !p_busy) begin
        scl_rises = 0; n_addr = 0; last_chg = -1; min_gap = 1 << 30; gap_bad = 0;
        mack_ok = 0; mack_hit = 0;
      end
      if (scl_o != p_scl || sda_o != p_sdo || sda_oe != p_oe) begin
        if (last_chg >= 0) begin
          if (cyc - last_chg < min_gap) min_gap = cyc - last_chg;
          if (((cyc - last_chg) % (int'(settle_div) + 1)) != 0) gap_bad = 1;
        end
        last_chg = cyc;
      end
      if (!p_scl && scl_o) scl_rises++;
      if (p_scl && scl_o && p_ln && !ln) begin
        st = S_ADDR; bc = 0; slave_low = 1'b0;
      end else if (p_scl && scl_o && !p_ln && ln) begin
        st = S_IDLE; bc = 0; slave_low = 1'b0;
      end else if (!p_scl && scl_o && st != S_IDLE) begin
        if (bc < 8) begin sh = {sh[6:0], ln}; bc++; end
        else begin
          bc = 0;
          if (st == S_RD) begin mack_hit = 1; mack_ok = sda_oe && !sda_o; end
        end
      end else if (p_scl && !scl_o && st != S_IDLE) begin
        if (bc == 8) begin
          case (st)
            S_ADDR: begin
              if (n_addr < 2) addr_log[n_addr] = sh;
              n_addr++;
              if (sh[7:1] == 7'h68 && !nack_mode) begin
                slave_low = 1'b1; st = sh[0] ? S_RD : S_REG;
              end else begin
                slave_low = 1'b0; st = S_IDLE;
              end
            end
            S_REG:  begin ptr = sh[5:0]; reg_seen = sh; slave_low = 1'b1; st = S_WDAT; end
            S_WDAT: begin mem[ptr] = sh; slave_low = 1'b1; end
            default: begin slave_low = 1'b0; st = S_IDLE; end
          endcase
        end else if (st == S_RD) slave_low = ~mem[ptr][7-bc];
        else slave_low = 1'b0;
      end
    end
    p_scl = scl_o; p_ln = sda_i; p_sdo = sda_o; p_oe = sda_oe; p_busy = busy;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  logic [7:0] got_rd;
  logic       got_nack;
  bit         got_done;

  task automatic run(input logic rd, input logic [5:0] r, input logic [7:0] wd);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_reg = r; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    got_done = done;
    got_rd = rsp_rdata;
    got_nack = nack_seen;
    chk(got_done, "R9 done reached", 32'(got_done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_rd = 1'b0; req_reg = 0; req_wdata = 0;
    settle_div = 16'd0; nack_mode = 1'b0;
    repeat (4) @(negedge clk);
    chk(scl_o && sda_o && sda_oe, "R1 lines idle in reset", {scl_o, sda_o, sda_oe}, 3'b111);
    chk(req_ready && !busy && !done, "R1 ready in reset", {req_ready, busy, done}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl_o && sda_o && sda_oe && !busy, "R1 idle after reset", {scl_o, sda_o, sda_oe, busy}, 4'b1110);

    for (int a = 0; a < 63; a++) begin
      run(1'b0, 6'(a), pat(a));
      chk(mem[a] == pat(a), "R2 target stored byte", mem[a], pat(a));
      chk(n_addr == 1 && addr_log[0] == 8'hD0, "R2 write address byte", addr_log[0], 8'hD0);
      chk(reg_seen == 8'(a), "R2 register byte", reg_seen, a);
      chk(!got_nack, "R5 acknowledged write", got_nack, 0);
      chk(scl_rises == 28, "R7 write SCL rises", scl_rises, 28);
      chk(min_gap == 1 && !gap_bad, "R6 gap at div 0", min_gap, 1);
      @(negedge clk);
      chk(!done && !busy, "R9 done single pulse", {done, busy}, 0);
    end

    for (int a = 0; a < 63; a++) begin
      run(1'b1, 6'(a), 8'h00);
      chk(got_rd == pat(a), "R3 read data", got_rd, pat(a));
      chk(n_addr == 2 && addr_log[0] == 8'hD0 && addr_log[1] == 8'hD1,
          "R3 read address bytes", {addr_log[0], addr_log[1]}, 16'hD0D1);
      chk(mack_hit && mack_ok, "R4 master drives ack low", {mack_hit, mack_ok}, 2'b11);
      chk(!got_nack, "R5 acknowledged read", got_nack, 0);
      chk(scl_rises == 37, "R7 read SCL rises", scl_rises, 37);
    end

    run(1'b0, 6'd7, 8'hC3);
    chk(rsp_rdata == pat(62), "R9 rdata held over write", rsp_rdata, pat(62));

    settle_div = 16'd3;
    run(1'b0, 6'd20, 8'h5A);
    chk(min_gap == 4 && !gap_bad, "R6 write gap at div 3", min_gap, 4);
    run(1'b1, 6'd20, 8'h00);
    chk(got_rd == 8'h5A, "R3 read at div 3", got_rd, 8'h5A);
    chk(min_gap == 4 && !gap_bad, "R6 read gap at div 3", min_gap, 4);
    settle_div = 16'd0;

    nack_mode = 1'b1;
    run(1'b0, 6'd10, 8'h77);
    chk(got_nack, "R5 nack flagged on write", got_nack, 1);
    chk(scl_rises == 28, "R5 write ran to stop", scl_rises, 28);
    run(1'b1, 6'd10, 8'h00);
    chk(got_nack && got_rd == 8'hFF, "R5 nack read", {got_nack, got_rd}, 9'h1FF);
    nack_mode = 1'b0;
    run(1'b1, 6'd10, 8'h00);
    chk(got_rd == pat(10), "R5 nacked write left register", got_rd, pat(10));

    @(negedge clk);
    req_valid = 1'b1; req_rd = 1'b0; req_reg = 6'h3F; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    chk(addr_err && !busy && req_ready, "R10 reject pulse", {addr_err, busy, req_ready}, 3'b101);
    begin
      int moves;
      moves = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (busy || done || addr_err || !scl_o || !sda_o || !sda_oe) moves++;
      end
      chk(moves == 0, "R10 no bus activity", moves, 0);
    end

    fork
      run(1'b0, 6'd5, 8'h3C);
      begin
        repeat (4) @(negedge clk);
        chk(busy && !req_ready, "R8 busy during transfer", {busy, req_ready}, 2'b10);
        req_valid = 1'b1; req_reg = 6'd6; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 1'b0; req_reg = 6'd5; req_wdata = 8'h3C;
      end
    join
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (busy) extra++;
      end
      chk(extra == 0, "R8 busy request started nothing", extra, 0);
    end
    chk(mem[6] == pat(6), "R8 register 6 untouched", mem[6], pat(6));
    chk(mem[5] == 8'h3C, "R8 accepted write stored", mem[5], 8'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule